// File: doc/BRIEF.md
# Segmented Vector Adder with Carry-Out Mode

This block adds two 128-bit vectors lane by lane. The lane width is chosen for each operation by a size code. Lanes can be 8, 16, 32, 64 or 128 bits wide. The adder has two modes. In sum mode it returns each lane's sum, wrapped to the lane width. In carry mode it returns, for each lane, only the unsigned carry out of that lane's addition, as a value of 0 or 1.

Internally the 128-bit datapath is cut into byte segments. Each segment passes its carry to the next one only when both lie inside the same lane. A single carry chain therefore serves every lane width. The widest lane spans both 64-bit halves, so the carry out of the low half flows into the high half.

A caller presents the operands with a one-cycle strobe and reads the registered result one clock later, when a completion pulse appears. A size code the block does not support raises an exception flag alongside that pulse, and the result register is left untouched.

Top module: `vadd_carry_unit`

## Requirements
- R1: Size codes 0, 1, 2, 3 and 4 select lanes of 8, 16, 32, 64 and 128 bits. Lane k occupies bits [k*W+W-1 : k*W], where W is the lane width.
- R2: A size code above 4 sets `spec_exc` together with `done` and leaves `result` unchanged. A legal code clears `spec_exc` together with `done`.
- R3: With `op_sel` = 0 (sum mode), each lane of `result` is (a + b) mod 2^W. No carry passes from one lane into the next.
- R4: With 128-bit lanes in sum mode, the carry out of bits [63:0] propagates into bits [127:64].
- R5: With `op_sel` = 1 (carry mode), bit 0 of each lane is 1 exactly when the unsigned sum of that lane pair exceeds 2^W - 1. Every other bit of the lane is 0.
- R6: With 128-bit lanes in carry mode, bits [127:1] of `result` are 0 and bit 0 is the carry out of the full 128-bit sum.
- R7: `result`, `spec_exc` and a single-cycle `done` pulse appear on the clock edge that samples `in_valid` high. `done` is low in every cycle that does not follow a strobe.
- R8: While reset is active, `result`, `done` and `spec_exc` are all 0.
- R9: Without a strobe, `result` holds its last value, whatever the operand and mode inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe; operands and controls are sampled with it |
| op_a | input | 128 | First operand vector |
| op_b | input | 128 | Second operand vector |
| elem_size | input | 3 | Lane size code (0..4 legal) |
| op_sel | input | 1 | 0 = lane sums, 1 = lane carry-outs |
| result | output | 128 | Registered result vector |
| done | output | 1 | Completion pulse, one cycle after a strobe |
| spec_exc | output | 1 | Illegal size code flag, valid while `done` is high |

## Verification
Some properties are checked by assertions on every cycle:
- `done` tracks the strobe exactly one cycle later.
- The exception flag matches the legality of the sampled size code.
- `result` does not move on an exception or when there is no strobe.
- In carry mode, no bit other than each lane's least significant bit is ever set.

The numeric behaviour needs the bench's directed scenarios. These cover wrap-around within a lane, the absence of carries across lane boundaries at every width, the carry passing across the 64-bit seam, and the exact 0/1 carry values.

// File: rtl/vadd_pkg.sv
package vadd_pkg;
   typedef enum logic {
      VOP_SUM   = 1'b0,
      VOP_CARRY = 1'b1
   } vop_e;
endpackage

// File: rtl/vadd_seg_chain.sv
module vadd_seg_chain #(
   parameter int DATA_W = 128,
   parameter int SEG_W  = 8,
   localparam int NUM_SEG = DATA_W / SEG_W
) (
   input  logic [DATA_W-1:0]  a_i,
   input  logic [DATA_W-1:0]  b_i,
   input  logic [NUM_SEG-1:0] seg_first_i,
   output logic [DATA_W-1:0]  sum_o,
   output logic [NUM_SEG-1:0] seg_cout_o
);
   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      logic          cin;
      logic          cout;
      logic [SEG_W:0] wide;
      if (s == 0) begin : g_head
         assign cin = 1'b0;
      end else begin : g_link
         assign cin = seg_first_i[s] ? 1'b0 : g_seg[s-1].cout;
      end
      assign wide = {1'b0, a_i[s*SEG_W +: SEG_W]} + {1'b0, b_i[s*SEG_W +: SEG_W]}
                  + {{SEG_W{1'b0}}, cin};
      assign cout = wide[SEG_W];
      assign sum_o[s*SEG_W +: SEG_W] = wide[SEG_W-1:0];
      assign seg_cout_o[s] = cout;
   end
endmodule

// File: rtl/vadd_pack.sv
module vadd_pack
   import vadd_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int SEG_W  = 8,
   localparam int NUM_SEG = DATA_W / SEG_W,
   localparam int IDX_W   = $clog2(NUM_SEG)
) (
   input  vop_e               op_i,
   input  logic [DATA_W-1:0]  sum_i,
   input  logic [NUM_SEG-1:0] seg_cout_i,
   input  logic [NUM_SEG-1:0] seg_first_i,
   input  logic [IDX_W-1:0]   span_m1_i,
   output logic [DATA_W-1:0]  res_o
);
   for (genvar s = 0; s < NUM_SEG; s++) begin : g_out
      logic [IDX_W-1:0] top_idx;
      logic             lane_c;
      assign top_idx = IDX_W'(s) | span_m1_i;
      assign lane_c  = seg_cout_i[top_idx];
      always_comb begin
         if (op_i == VOP_CARRY)
            res_o[s*SEG_W +: SEG_W] = seg_first_i[s] ? {{(SEG_W-1){1'b0}}, lane_c}
                                                     : '0;
         else
            res_o[s*SEG_W +: SEG_W] = sum_i[s*SEG_W +: SEG_W];
      end
   end
endmodule

// File: rtl/vadd_carry_unit.sv
module vadd_carry_unit
   import vadd_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int SEG_W  = 8,
   parameter int CODE_W = 3,
   localparam int NUM_SEG  = DATA_W / SEG_W,
   localparam int IDX_W    = $clog2(NUM_SEG),
   localparam int MAX_CODE = IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [CODE_W-1:0] elem_size,
   input  logic              op_sel,
   output logic [DATA_W-1:0] result,
   output logic              done,
   output logic              spec_exc
);
   if (DATA_W % SEG_W != 0) begin : g_bad_split
      $error("DATA_W must be a multiple of SEG_W");
   end
   if (NUM_SEG < 2 || (1 << IDX_W) != NUM_SEG) begin : g_bad_count
      $error("segment count must be a power of two, at least 2");
   end
   if ((1 << CODE_W) <= MAX_CODE) begin : g_bad_code
      $error("CODE_W too narrow for all lane sizes");
   end

   logic              code_bad;
   logic [CODE_W-1:0] code_c;
   logic [IDX_W-1:0]  span_m1;
   logic [NUM_SEG-1:0] seg_first;
   logic [DATA_W-1:0] sum_w;
   logic [NUM_SEG-1:0] seg_cout;
   logic [DATA_W-1:0] res_next;

   assign code_bad = elem_size > CODE_W'(MAX_CODE);
   assign code_c   = code_bad ? CODE_W'(MAX_CODE) : elem_size;
   assign span_m1  = ~({IDX_W{1'b1}} << code_c);

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_first
      assign seg_first[s] = (IDX_W'(s) & span_m1) == '0;
   end

   vadd_seg_chain #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_chain (
      .a_i        (op_a),
      .b_i        (op_b),
      .seg_first_i(seg_first),
      .sum_o      (sum_w),
      .seg_cout_o (seg_cout)
   );

   vadd_pack #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_pack (
      .op_i       (vop_e'(op_sel)),
      .sum_i      (sum_w),
      .seg_cout_i (seg_cout),
      .seg_first_i(seg_first),
      .span_m1_i  (span_m1),
      .res_o      (res_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result   <= '0;
         done     <= 1'b0;
         spec_exc <= 1'b0;
      end else begin
         done <= in_valid;
         if (in_valid) begin
            spec_exc <= code_bad;
            if (!code_bad) result <= res_next;
         end
      end
   end
endmodule

// File: rtl/vadd_carry_unit_chk.sv
module vadd_carry_unit_chk #(
   parameter int DATA_W = 128,
   parameter int CODE_W = 3,
   parameter int MAX_CODE = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [CODE_W-1:0] elem_size,
   input logic              op_sel,
   input logic [DATA_W-1:0] result,
   input logic              done,
   input logic              spec_exc
);
   function automatic logic [DATA_W-1:0] lane_lsbs(input logic [CODE_W-1:0] c);
      logic [DATA_W-1:0] m;
      int w;
      m = '0;
      w = 8 << c;
      for (int k = 0; k < DATA_W; k++)
         if (k % w == 0) m[k] = 1'b1;
      return m;
   endfunction

   AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> done); // R7
   AST_DONE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(in_valid)); // R7
   AST_EXC_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (spec_exc == ($past(elem_size) > CODE_W'(MAX_CODE)))); // R2
   AST_EXC_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && spec_exc) |-> $stable(result)); // R2
   AST_IDLE_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result)); // R9
   AST_CARRY_ONLY_LSBS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !spec_exc && $past(op_sel))
         |-> ((result & ~lane_lsbs($past(elem_size))) == '0)); // R5
endmodule

bind vadd_carry_unit vadd_carry_unit_chk #(
   .DATA_W(DATA_W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .elem_size(elem_size),
   .op_sel(op_sel), .result(result), .done(done), .spec_exc(spec_exc)
);

// File: tb/vadd_carry_unit_bench.sv
module vadd_carry_unit_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] op_a = '0;
   logic [127:0] op_b = '0;
   logic [2:0]   elem_size = '0;
   logic         op_sel = 1'b0;
   logic [127:0] result;
   logic         done;
   logic         spec_exc;
   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   vadd_carry_unit u_vadd_carry_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .elem_size(elem_size), .op_sel(op_sel), .result(result), .done(done),
      .spec_exc(spec_exc)
   );

   function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                          input int code, input bit carry);
      logic [127:0] r;
      logic [128:0] m, ea, eb, s;
      int w;
      r = '0;
      w = 8 << code;
      m = (129'd1 << w) - 129'd1;
      for (int e = 0; e < 128 / w; e++) begin
         ea = ({1'b0, a} >> (e * w)) & m;
         eb = ({1'b0, b} >> (e * w)) & m;
         s  = ea + eb;
         if (carry) r = r | (128'((s >> w) & 129'd1) << (e * w));
         else       r = r | (128'(s & m) << (e * w));
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic fire(input logic [127:0] a, input logic [127:0] b,
                       input int code, input bit carry);
      @(negedge clk);
      op_a = a; op_b = b; elem_size = 3'(code); op_sel = carry; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R8 result", result, '0);
      chk("R8 done", 128'(done), 0);
      chk("R8 spec_exc", 128'(spec_exc), 0);
   endtask

   task automatic t_sum_all_sizes;
      logic [127:0] a, b;
      a = 128'hFF01_7F80_FFFF_0001_8000_0000_FFFF_FFFF;
      b = 128'h0101_8080_0001_FFFF_8000_0001_0000_0001;
      for (int c = 0; c <= 4; c++) begin
         fire(a, b, c, 1'b0);
         chk($sformatf("R1 R3 sum size %0d", c), result, model(a, b, c, 0));
         chk("R7 done", 128'(done), 1);
         chk("R2 no exc", 128'(spec_exc), 0);
      end
   endtask

   task automatic t_lane_isolation;
      for (int c = 0; c <= 3; c++) begin
         fire({128{1'b1}}, 128'h1, c, 1'b0);
         chk($sformatf("R3 no cross size %0d", c), result,
             {128{1'b1}} & ~((128'd1 << (8 << c)) - 128'd1));
      end
   endtask

   task automatic t_seam_128;
      fire(128'h0000_0000_0000_0005_FFFF_FFFF_FFFF_FFFF, 128'h1, 4, 1'b0);
      chk("R4 seam carry", result, 128'h0000_0000_0000_0006_0000_0000_0000_0000);
      fire({128{1'b1}}, 128'h2, 4, 1'b0);
      chk("R4 full wrap", result, 128'h1);
   endtask

   task automatic t_carry_mode;
      logic [127:0] a, b;
      a = 128'hFF00_8000_FFFF_FFFF_FFFF_FFFF_0000_0001;
      b = 128'h0100_8000_0000_0001_0000_0000_0000_FFFF;
      for (int c = 0; c <= 3; c++) begin
         fire(a, b, c, 1'b1);
         chk($sformatf("R5 carry size %0d", c), result, model(a, b, c, 1));
      end
      fire(128'hFE, 128'h01, 0, 1'b1);
      chk("R5 no overflow at max", result, '0);
   endtask

   task automatic t_carry_128;
      fire({128{1'b1}}, 128'h1, 4, 1'b1);
      chk("R6 carry set", result, 128'h1);
      fire(128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0000,
           128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF, 4, 1'b1);
      chk("R6 carry clear", result, 128'h0);
      fire(128'h8000_0000_0000_0000_8000_0000_0000_0000,
           128'h7FFF_FFFF_FFFF_FFFF_8000_0000_0000_0000, 4, 1'b1);
      chk("R6 seam carry out", result, 128'h1);
   endtask

   task automatic t_exception;
      logic [127:0] keep;
      fire(128'h1234, 128'h1111, 2, 1'b0);
      keep = result;
      fire(128'hAAAA, 128'h5555, 5, 1'b0);
      chk("R2 exc flag c5", 128'(spec_exc), 1);
      chk("R2 exc done", 128'(done), 1);
      chk("R2 result kept", result, keep);
      fire(128'hAAAA, 128'h5555, 7, 1'b1);
      chk("R2 exc flag c7", 128'(spec_exc), 1);
      chk("R2 result kept c7", result, keep);
      fire(128'h1, 128'h1, 0, 1'b0);
      chk("R2 exc cleared", 128'(spec_exc), 0);
   endtask

   task automatic t_idle_hold;
      logic [127:0] keep;
      fire(128'h77, 128'h11, 1, 1'b0);
      keep = result;
      @(negedge clk);
      chk("R7 done single pulse", 128'(done), 0);
      op_a = 128'hDEAD; op_b = 128'hBEEF; op_sel = 1'b1; elem_size = 3'd3;
      @(negedge clk);
      @(negedge clk);
      chk("R9 idle hold", result, keep);
      chk("R7 done idle", 128'(done), 0);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_sum_all_sizes;
      t_lane_isolation;
      t_seam_128;
      t_carry_mode;
      t_carry_128;
      t_exception;
      t_idle_hold;
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule